// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Channel Bank

This block gathers a set of peripheral interrupt channels and hands the core a single request at a time. Every channel keeps four pieces of state: a pending flag, an enable (mask) flag, a 3-bit priority and a vector number. A hardware trigger pulse sets the pending flag. Software can also set or clear that flag through the register port, so it can poll a channel, cancel a request, or raise one on purpose.

Each cycle the block looks for the best channel that is allowed to request. A channel is allowed when it is pending, its mask flag is set, the global enable is high, its priority is not the reserved level 7, and its priority is numerically below the core's current level. The winner is the channel with the smallest priority value. The lowest index breaks a tie. The winner's vector and priority are registered and presented together with a valid flag. When the core acknowledges, the winner's pending flag is cleared.

Top module: `prio_irq_bank`

## Requirements
- R1: After reset, reqValid, reqVector and reqPrio are 0, and every channel reads back with pending 0, mask 0, priority 7 and vector 0.
- R2: Each channel's register word holds pending in bit 0, mask in bit 1, priority in bits 4:2 and vector in bits 11:5. A write replaces every field of the channel selected by regAddr. The read data shows the selected channel's word in the same cycle.
- R3: A one-cycle trigger pulse sets the channel's pending flag. A trigger also wins over a software write that clears the flag in the same cycle, and over an acknowledge that clears it in the same cycle.
- R4: Writing pending 1 makes a masked-in channel request. Writing pending 0 withdraws the request.
- R5: A channel whose mask flag is 0 never requests, but its pending flag still reads back as set.
- R6: While globalEn is 0, no channel requests.
- R7: A channel with priority 7 is never presented, whatever the value of cpuPrio.
- R8: A channel is presented only if its priority is strictly below cpuPrio.
- R9: The smallest priority value wins. Among equal priorities, the lowest channel index wins.
- R10: The outputs are registered. A change in channel state, globalEn or cpuPrio shows on reqValid, reqVector and reqPrio after exactly one rising edge. reqVector and reqPrio are 0 while reqValid is 0.
- R11: ackIn while reqValid is 1 clears the presented channel's pending flag, and the next output excludes that channel. ackIn while reqValid is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | NUM_CH | Per-channel trigger pulses |
| regWrEn | input | 1 | Write strobe for the selected channel word |
| regAddr | input | IDX_W | Channel selected for read and write |
| regWrData | input | WORD_W | Channel word to write |
| regRdData | output | WORD_W | Word of the selected channel |
| globalEn | input | 1 | Global interrupt enable |
| cpuPrio | input | PRIO_W | Core's current priority level |
| ackIn | input | 1 | Acknowledge of the presented request |
| reqValid | output | 1 | A request is presented |
| reqVector | output | VEC_W | Vector of the presented channel |
| reqPrio | output | PRIO_W | Priority of the presented channel |

## Verification
The acknowledge check assumes that the core does not write the winning channel's register in the same cycle as it acknowledges. The stimulus never overlaps those two actions. The eligibility checks assume that cpuPrio, globalEn and the register writes all change on clock edges. The stimulus drives every input on the falling edge and holds it for whole cycles. The trigger pulses always last exactly one cycle, which matches the pulse assumption in the requirements.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // channel word field positions (software visible)
  localparam int unsigned PEND_BIT = 0;
  localparam int unsigned MASK_BIT = 1;
  localparam int unsigned PRIO_LSB = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic wrFire;
    logic ackFire;
  } strobe_t;
endpackage

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WORD_W = 2 + PRIO_W + VEC_W,
  localparam int unsigned VEC_LSB = PRIO_LSB + PRIO_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        trigIn,
  input  strobe_t                  strobe,
  input  logic [IDX_W-1:0]         regAddr,
  input  logic [WORD_W-1:0]        regWrData,
  input  logic [IDX_W-1:0]         ackIdx,
  output logic [WORD_W-1:0]        regRdData,
  output logic [NUM_CH-1:0]        pendVec,
  output logic [NUM_CH-1:0]        maskVec,
  output logic [NUM_CH*PRIO_W-1:0] prioFlat,
  output logic [NUM_CH*VEC_W-1:0]  vecFlat
);
  localparam logic [PRIO_W-1:0] PRIO_RESET = {PRIO_W{1'b1}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              pendR;
    logic              maskR;
    logic [PRIO_W-1:0] prioR;
    logic [VEC_W-1:0]  vecR;
    logic              wrHit;
    logic              ackHit;

    assign wrHit  = strobe.wrFire  && (regAddr == IDX_W'(c));
    assign ackHit = strobe.ackFire && (ackIdx  == IDX_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendR <= 1'b0;
        maskR <= 1'b0;
        prioR <= PRIO_RESET;
        vecR  <= '0;
      end else begin
        if (wrHit) begin
          maskR <= regWrData[MASK_BIT];
          prioR <= regWrData[PRIO_LSB +: PRIO_W];
          vecR  <= regWrData[VEC_LSB +: VEC_W];
        end
        // trigger dominates software clear and acknowledge clear
        if (trigIn[c])   pendR <= 1'b1;
        else if (wrHit)  pendR <= regWrData[PEND_BIT];
        else if (ackHit) pendR <= 1'b0;
      end
    end

    assign pendVec[c] = pendR;
    assign maskVec[c] = maskR;
    assign prioFlat[c*PRIO_W +: PRIO_W] = prioR;
    assign vecFlat[c*VEC_W +: VEC_W]    = vecR;
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == IDX_W'(i)) begin
        regRdData = {vecFlat[i*VEC_W +: VEC_W], prioFlat[i*PRIO_W +: PRIO_W],
                     maskVec[i], pendVec[i]};
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        pendVec,
  input  logic [NUM_CH-1:0]        maskVec,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  input  logic [NUM_CH*VEC_W-1:0]  vecFlat,
  input  logic                     globalEn,
  input  logic [PRIO_W-1:0]        cpuPrio,
  input  logic                     ackIn,
  input  logic                     regWrEn,
  output strobe_t                  strobe,
  output logic [IDX_W-1:0]         winIdx,
  output logic                     reqValid,
  output logic [VEC_W-1:0]         reqVector,
  output logic [PRIO_W-1:0]        reqPrio
);
  localparam logic [PRIO_W-1:0] PRIO_NEVER = {PRIO_W{1'b1}};

  logic              found;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic [VEC_W-1:0]  bestVec;
  logic              ackFire;

  assign ackFire        = ackIn && reqValid;
  assign strobe.ackFire = ackFire;
  assign strobe.wrFire  = regWrEn;

  // strict '<' on priority keeps the lowest index among equals
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    bestVec  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pendVec[i] && maskVec[i] && globalEn
          && (prioFlat[i*PRIO_W +: PRIO_W] != PRIO_NEVER)
          && (prioFlat[i*PRIO_W +: PRIO_W] < cpuPrio)
          && !(ackFire && (winIdx == IDX_W'(i)))
          && (!found || (prioFlat[i*PRIO_W +: PRIO_W] < bestPrio))) begin
        found    = 1'b1;
        bestIdx  = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        bestVec  = vecFlat[i*VEC_W +: VEC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqVector <= '0;
      reqPrio   <= '0;
      winIdx    <= '0;
    end else begin
      reqValid  <= found;
      reqVector <= bestVec;
      reqPrio   <= bestPrio;
      winIdx    <= bestIdx;
    end
  end
endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned WORD_W = 2 + PRIO_W + VEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              globalEn,
  input  logic [PRIO_W-1:0] cpuPrio,
  input  logic              ackIn,
  output logic              reqValid,
  output logic [VEC_W-1:0]  reqVector,
  output logic [PRIO_W-1:0] reqPrio
);
  strobe_t                  strobe;
  logic [IDX_W-1:0]         winIdx;
  logic [NUM_CH-1:0]        pendVec;
  logic [NUM_CH-1:0]        maskVec;
  logic [NUM_CH*PRIO_W-1:0] prioFlat;
  logic [NUM_CH*VEC_W-1:0]  vecFlat;

  prio_irq_dp #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .strobe(strobe),
    .regAddr(regAddr), .regWrData(regWrData), .ackIdx(winIdx),
    .regRdData(regRdData), .pendVec(pendVec), .maskVec(maskVec),
    .prioFlat(prioFlat), .vecFlat(vecFlat)
  );

  prio_irq_ctrl #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .maskVec(maskVec),
    .prioFlat(prioFlat), .vecFlat(vecFlat), .globalEn(globalEn),
    .cpuPrio(cpuPrio), .ackIn(ackIn), .regWrEn(regWrEn), .strobe(strobe),
    .winIdx(winIdx), .reqValid(reqValid), .reqVector(reqVector),
    .reqPrio(reqPrio)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] trigIn,
  input logic              regWrEn,
  input logic              globalEn,
  input logic [PRIO_W-1:0] cpuPrio,
  input logic              ackIn,
  input logic              reqValid,
  input logic [PRIO_W-1:0] reqPrio,
  input logic [NUM_CH-1:0] pendVec,
  input logic [NUM_CH-1:0] maskVec,
  input logic [IDX_W-1:0]  winIdx
);
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] maskQ;
  logic              enQ;
  logic [PRIO_W-1:0] cpuQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      enQ   <= 1'b0;
      cpuQ  <= '0;
    end else begin
      pendQ <= pendVec;
      maskQ <= maskVec;
      enQ   <= globalEn;
      cpuQ  <= cpuPrio;
    end
  end

  assert_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> pendQ[winIdx]);
  assert_masked_in_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> maskQ[winIdx]);
  assert_global_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> enQ);
  assert_no_level7_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqPrio != {PRIO_W{1'b1}}));
  assert_below_cpu_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqPrio < cpuQ));
  assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && reqValid && !regWrEn && !trigIn[winIdx]) |=> !pendVec[$past(winIdx)]);
endmodule

bind prio_irq_bank prio_irq_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .regWrEn(regWrEn),
  .globalEn(globalEn), .cpuPrio(cpuPrio), .ackIn(ackIn), .reqValid(reqValid),
  .reqPrio(reqPrio), .pendVec(pendVec), .maskVec(maskVec), .winIdx(winIdx)
);

// File: tb/prio_irq_bank_tb.sv
module prio_irq_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  trigIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [11:0] regWrData = '0;
  logic [11:0] regRdData;
  logic        globalEn = 1'b0;
  logic [2:0]  cpuPrio = '0;
  logic        ackIn = 1'b0;
  logic        reqValid;
  logic [6:0]  reqVector;
  logic [2:0]  reqPrio;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_bank u_dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .globalEn(globalEn), .cpuPrio(cpuPrio), .ackIn(ackIn),
    .reqValid(reqValid), .reqVector(reqVector), .reqPrio(reqPrio)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectEq(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectOut(string tag, int v, int vec, int pr);
    expectEq({tag, " valid"}, int'(reqValid), v);
    expectEq({tag, " vector"}, int'(reqVector), vec);
    expectEq({tag, " prio"}, int'(reqPrio), pr);
  endtask

  task automatic wrCh(int ch, bit pend, bit mask, int prio, int vec);
    regAddr   = 3'(ch);
    regWrData = {7'(vec), 3'(prio), mask, pend};
    regWrEn   = 1'b1;
    tick();
    regWrEn   = 1'b0;
  endtask

  task automatic rdCh(int ch, output logic [11:0] w);
    regAddr = 3'(ch);
    #1;
    w = regRdData;
  endtask

  task automatic clearAll();
    for (int c = 0; c < NCH; c++) wrCh(c, 0, 0, 7, 0);
    tick(2);
  endtask

  task automatic testReset();
    logic [11:0] w;
    expectOut("R1 reset", 0, 0, 0);
    for (int c = 0; c < NCH; c++) begin
      rdCh(c, w);
      expectEq("R1 reset word", int'(w), 28);
    end
  endtask

  task automatic testTrigger();
    logic [11:0] w;
    clearAll();
    globalEn = 1'b1; cpuPrio = 3'd7;
    wrCh(2, 0, 1, 3, 'h22);
    rdCh(2, w);
    expectEq("R2 word layout", int'(w), ('h22 << 5) | (3 << 2) | 2);
    tick();
    trigIn = 8'b0000_0100;
    tick();
    trigIn = '0;
    rdCh(2, w);
    expectEq("R3 trigger sets pending", int'(w[0]), 1);
    expectEq("R10 one edge of latency", int'(reqValid), 0);
    tick();
    expectOut("R3 trigger request", 1, 'h22, 3);
    // trigger in the same cycle as a software clear
    regAddr = 3'd5; regWrData = {7'h05, 3'd4, 1'b1, 1'b0}; regWrEn = 1'b1;
    trigIn = 8'b0010_0000;
    tick();
    regWrEn = 1'b0; trigIn = '0;
    rdCh(5, w);
    expectEq("R3 trigger beats write clear", int'(w[0]), 1);
  endtask

  task automatic testSoftware();
    logic [11:0] w;
    clearAll();
    wrCh(1, 1, 1, 4, 'h15);
    tick();
    expectOut("R4 software set", 1, 'h15, 4);
    wrCh(1, 0, 1, 4, 'h15);
    tick();
    expectOut("R4 software clear", 0, 0, 0);
    rdCh(1, w);
    expectEq("R4 pending read after clear", int'(w[0]), 0);
  endtask

  task automatic testMask();
    logic [11:0] w;
    clearAll();
    wrCh(3, 1, 0, 2, 9);
    tick(2);
    expectOut("R5 masked out", 0, 0, 0);
    rdCh(3, w);
    expectEq("R5 pending still visible", int'(w[0]), 1);
    wrCh(3, 1, 1, 2, 9);
    tick();
    expectOut("R5 masked in", 1, 9, 2);
  endtask

  task automatic testGlobal();
    globalEn = 1'b0;
    tick();
    expectOut("R6 global disable", 0, 0, 0);
    globalEn = 1'b1;
    tick();
    expectOut("R6 global enable", 1, 9, 2);
  endtask

  task automatic testLevel7();
    clearAll();
    cpuPrio = 3'd7;
    wrCh(0, 1, 1, 7, 5);
    tick(2);
    expectOut("R7 level 7 never", 0, 0, 0);
  endtask

  task automatic testCpuPrio();
    clearAll();
    wrCh(2, 1, 1, 3, 'h33);
    cpuPrio = 3'd3;
    tick(2);
    expectOut("R8 equal level blocked", 0, 0, 0);
    cpuPrio = 3'd4;
    #1;
    expectEq("R10 no change before edge", int'(reqValid), 0);
    tick();
    expectOut("R8 lower level passes", 1, 'h33, 3);
    cpuPrio = 3'd7;
    tick();
  endtask

  task automatic testArb();
    clearAll();
    wrCh(5, 1, 1, 2, 'h55);
    wrCh(3, 1, 1, 2, 'h33);
    tick();
    expectOut("R9 tie lowest index", 1, 'h33, 2);
    wrCh(6, 1, 1, 1, 'h66);
    tick();
    expectOut("R9 lower value wins", 1, 'h66, 1);
  endtask

  task automatic testAck();
    logic [11:0] w;
    clearAll();
    wrCh(1, 1, 1, 2, 'h11);
    wrCh(4, 1, 1, 5, 'h44);
    tick();
    expectOut("R11 before ack", 1, 'h11, 2);
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    expectOut("R11 next winner", 1, 'h44, 5);
    rdCh(1, w);
    expectEq("R11 acked pending cleared", int'(w[0]), 0);
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    expectOut("R11 none left", 0, 0, 0);
    rdCh(4, w);
    expectEq("R11 second ack cleared", int'(w[0]), 0);
  endtask

  task automatic testAckTrig();
    logic [11:0] w;
    clearAll();
    wrCh(6, 1, 1, 1, 'h60);
    tick();
    expectOut("R11 before ack with trigger", 1, 'h60, 1);
    ackIn = 1'b1; trigIn = 8'b0100_0000;
    tick();
    ackIn = 1'b0; trigIn = '0;
    rdCh(6, w);
    expectEq("R3 trigger beats ack", int'(w[0]), 1);
    tick();
    expectOut("R11 retriggered request", 1, 'h60, 1);
  endtask

  task automatic testAckIdle();
    logic [11:0] w;
    clearAll();
    wrCh(0, 1, 0, 2, 1);
    tick();
    expectEq("R11 idle valid", int'(reqValid), 0);
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    rdCh(0, w);
    expectEq("R11 idle ack ignored", int'(w[0]), 1);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    testReset();
    testTrigger();
    testSoftware();
    testMask();
    testGlobal();
    testLevel7();
    testCpuPrio();
    testArb();
    testAck();
    testAckTrig();
    testAckIdle();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule